// File: doc/BRIEF.md
# Configuration Register Write Merge Unit

This block applies 16-bit software writes to a small set of configuration registers whose bits carry different attributes. Each bit is reserved, read-only, write-1-to-clear, emulated, or passed through to the device. For every accepted write the unit computes two results. The first is the new value of the locally held emulated copy of the selected register. The second is the word to be written into the real device register. The merge is driven by a fixed per-register attribute table and by the byte enables of the write.

The forwarded word is the key part. In passthrough bits it carries what software wrote. In every other bit it carries the present device value, except that each write-1-to-clear bit is forced to 0 there. A read-modify-write by software therefore cannot clear a pending status flag by accident: such a flag clears only when software writes a 1 into an enabled byte.

The caller supplies the register index, byte enables, write data and the current device value. One cycle later it receives a forward strobe together with the merged word and the register index. A combinational read port returns the emulated copy of any register.

Top module: `cfgm_write_merge`

## Requirements
- R1: After reset, `fwd_valid_o` is 0. The emulated copies hold their initial values: 0x0008 for the power-management register and 0x0000 for the others.
- R2: On a write, the emulated copy changes only in the bits that are set in (emulate AND NOT read-only AND enabled-byte mask). Those bits take the written value and every other bit keeps its old value.
- R3: `wr_be_i[0]` enables bits 7:0 and `wr_be_i[1]` enables bits 15:8. A bit in a disabled byte is treated as not written.
- R4: Passthrough bits are the enabled bits whose emulate, read-only and reserved masks are all clear. In these bits the forwarded word equals the written data.
- R5: Every non-passthrough bit of the forwarded word equals the sampled device value, except that write-1-to-clear bits are 0 there.
- R6: `fwd_valid_o` pulses high in the cycle after an accepted write, and `fwd_data_o` and `fwd_sel_o` (the written index) are valid in that cycle. The emulated copy updates on the same clock edge.
- R7: The register index selects from this table of masks, given as reserved/read-only/write-1-to-clear/emulate:
  - 0 = status: 0x0007/0x06F8/0xF900/0x0010.
  - 1 = device status: 0xFFC0/0x0030/0x000F/0x0000.
  - 2 = link status: 0x0000/0x3FFF/0xC000/0x0000.
  - 3 = power-management control/status: 0x00F0/0x610C/0x8000/0x810B.
- R8: `emu_val_o` shows, without a clock delay, the emulated copy of the register chosen by `rd_sel_i`.
- R9: In a cycle without a write, no forward strobe follows and no emulated copy changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write accepted this cycle |
| wr_sel_i | input | 2 | Register index of the write |
| wr_be_i | input | 2 | Byte enables of the write |
| wr_data_i | input | 16 | Write data |
| dev_val_i | input | 16 | Current device register value |
| rd_sel_i | input | 2 | Register index for the read port |
| emu_val_o | output | 16 | Emulated copy of the selected register |
| fwd_valid_o | output | 1 | Forward strobe |
| fwd_sel_o | output | 2 | Register index of the forwarded word |
| fwd_data_o | output | 16 | Word to write into the device register |

## Verification
The bench drives partial-byte writes in which a whole byte of write-1-to-clear bits is disabled while the device reports them set. A design that passed the device value through unmasked would clear those flags on a plain write-back, so the forwarded word would show them as 1 where 0 is expected. Power-management writes of all ones exercise the overlap of the emulate and read-only masks. A design that ignored the read-only mask would corrupt the read-only bits of the emulated copy, and the read port would show the difference. Idle cycles and swapped byte lanes expose strobes that appear without a write and lanes that are mapped wrongly.

// File: rtl/cfgm_pkg.sv
package cfgm_pkg;
  localparam int DW   = 16;
  localparam int NREG = 4;
  localparam int SW   = $clog2(NREG);
  localparam int BW   = DW / 8;

  typedef struct packed {
    logic [DW-1:0] init;
    logic [DW-1:0] res;
    logic [DW-1:0] ro;
    logic [DW-1:0] w1c;
    logic [DW-1:0] emu;
  } attr_t;

  // index order is the decode order of the caller
  function automatic attr_t attr_of(input int idx);
    attr_t a;
    a = '0;
    case (idx)
      0: begin a.res = 16'h0007; a.ro = 16'h06F8; a.w1c = 16'hF900; a.emu = 16'h0010; end
      1: begin a.res = 16'hFFC0; a.ro = 16'h0030; a.w1c = 16'h000F; end
      2: begin a.ro = 16'h3FFF; a.w1c = 16'hC000; end
      3: begin a.init = 16'h0008; a.res = 16'h00F0; a.ro = 16'h610C;
               a.w1c = 16'h8000; a.emu = 16'h810B; end
      default: a = '0;
    endcase
    return a;
  endfunction
endpackage

// File: rtl/cfgm_be_expand.sv
module cfgm_be_expand #(
  parameter int DW = 16,
  localparam int BW = DW / 8
) (
  input  logic [BW-1:0] be_i,
  output logic [DW-1:0] mask_o
);
  for (genvar b = 0; b < BW; b++) begin : g_lane
    assign mask_o[b*8 +: 8] = {8{be_i[b]}};
  end
endmodule

// File: rtl/cfgm_merge.sv
module cfgm_merge
  import cfgm_pkg::*;
(
  input  attr_t         attr_i,
  input  logic [DW-1:0] valid_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] old_i,
  input  logic [DW-1:0] dev_i,
  output logic [DW-1:0] emu_next_o,
  output logic [DW-1:0] fwd_o
);
  logic [DW-1:0] emu_wr, thru;

  always_comb begin
    emu_wr     = attr_i.emu & ~attr_i.ro & valid_i;
    thru       = valid_i & ~(attr_i.emu | attr_i.ro | attr_i.res);
    emu_next_o = (wdata_i & emu_wr) | (old_i & ~emu_wr);
    // w1c bits outside the written lanes must never echo back a 1
    fwd_o      = (wdata_i & thru) | (dev_i & ~attr_i.w1c & ~thru);
  end
endmodule

// File: rtl/cfgm_emu_bank.sv
module cfgm_emu_bank
  import cfgm_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [SW-1:0] wsel_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [SW-1:0] rsel_a_i,
  input  logic [SW-1:0] rsel_b_i,
  output logic [DW-1:0] rdata_a_o,
  output logic [DW-1:0] rdata_b_o
);
  logic [DW-1:0] q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam attr_t A = attr_of(i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          q[i] <= A.init;
      else if (we_i && wsel_i == SW'(i))    q[i] <= wdata_i;
    end

    // R2: bits outside the emulate mask never move
    a_r2_nonemu_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $stable(q[i] & ~A.emu));
    // R9: without a write the copy holds
    a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_i |=> $stable(q[i]));
  end

  assign rdata_a_o = q[rsel_a_i];
  assign rdata_b_o = q[rsel_b_i];
endmodule

// File: rtl/cfgm_write_merge.sv
module cfgm_write_merge
  import cfgm_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  input  logic [SW-1:0] wr_sel_i,
  input  logic [BW-1:0] wr_be_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [DW-1:0] dev_val_i,
  input  logic [SW-1:0] rd_sel_i,
  output logic [DW-1:0] emu_val_o,
  output logic          fwd_valid_o,
  output logic [SW-1:0] fwd_sel_o,
  output logic [DW-1:0] fwd_data_o
);
  logic [DW-1:0] valid_mask, old_val, emu_next, fwd_next;
  attr_t         attr;

  assign attr = attr_of(int'(wr_sel_i));

  cfgm_be_expand #(.DW(DW)) u_be (
    .be_i   (wr_be_i),
    .mask_o (valid_mask)
  );

  cfgm_emu_bank u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_valid_i),
    .wsel_i    (wr_sel_i),
    .wdata_i   (emu_next),
    .rsel_a_i  (wr_sel_i),
    .rsel_b_i  (rd_sel_i),
    .rdata_a_o (old_val),
    .rdata_b_o (emu_val_o)
  );

  cfgm_merge u_merge (
    .attr_i     (attr),
    .valid_i    (valid_mask),
    .wdata_i    (wr_data_i),
    .old_i      (old_val),
    .dev_i      (dev_val_i),
    .emu_next_o (emu_next),
    .fwd_o      (fwd_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwd_valid_o <= 1'b0;
      fwd_sel_o   <= '0;
      fwd_data_o  <= '0;
    end else begin
      fwd_valid_o <= wr_valid_i;
      if (wr_valid_i) begin
        fwd_sel_o  <= wr_sel_i;
        fwd_data_o <= fwd_next;
      end
    end
  end

  a_r6_strobe_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i |=> fwd_valid_o && fwd_sel_o == $past(wr_sel_i));
  a_r9_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |=> !fwd_valid_o);
  a_r5_w1c_safe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && wr_be_i == '0 |=> (fwd_data_o & attr_of(int'(fwd_sel_o)).w1c) == '0);
  a_r4_full_write_thru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && wr_be_i == '1 |=>
      ((fwd_data_o ^ $past(wr_data_i)) & ~(attr_of(int'(fwd_sel_o)).emu |
        attr_of(int'(fwd_sel_o)).ro | attr_of(int'(fwd_sel_o)).res)) == '0);
endmodule

// File: tb/cfgm_write_merge_bench.sv
module cfgm_write_merge_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        wr_valid_i = 1'b0;
  logic [1:0]  wr_sel_i = '0, wr_be_i = '0, rd_sel_i = '0;
  logic [15:0] wr_data_i = '0, dev_val_i = '0;
  logic [15:0] emu_val_o, fwd_data_o;
  logic        fwd_valid_o;
  logic [1:0]  fwd_sel_o;

  int compared = 0, mismatched = 0;
  bit done = 0;

  // R7: mask table held independently in the bench
  logic [15:0] t_res [4] = '{16'h0007, 16'hFFC0, 16'h0000, 16'h00F0};
  logic [15:0] t_ro  [4] = '{16'h06F8, 16'h0030, 16'h3FFF, 16'h610C};
  logic [15:0] t_w1c [4] = '{16'hF900, 16'h000F, 16'hC000, 16'h8000};
  logic [15:0] t_emu [4] = '{16'h0010, 16'h0000, 16'h0000, 16'h810B};

  logic [15:0] m_emu [4];
  logic        m_fv;
  logic [1:0]  m_fs;
  logic [15:0] m_fd;

  cfgm_write_merge u_cfgm_write_merge (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare outputs against the model, then apply the next stimulus and advance the model
  task automatic step(input logic v, input logic [1:0] s, input logic [1:0] be,
                      input logic [15:0] d, input logic [15:0] dev, input logic [1:0] rs);
    logic [15:0] vm, wm, th;
    @(negedge clk_i);
    check("R6 fwd_valid", {15'd0, fwd_valid_o}, {15'd0, m_fv});
    if (m_fv) begin
      check("R6 fwd_sel", {14'd0, fwd_sel_o}, {14'd0, m_fs});
      check("R4 R5 fwd_data", fwd_data_o, m_fd);
    end
    check("R2 R8 emu_val", emu_val_o, m_emu[rd_sel_i]);
    wr_valid_i = v; wr_sel_i = s; wr_be_i = be; wr_data_i = d;
    dev_val_i = dev; rd_sel_i = rs;
    m_fv = v;
    if (v) begin
      vm = {{8{be[1]}}, {8{be[0]}}};  // R3 lane mapping
      wm = vm & t_emu[s] & ~t_ro[s];
      th = vm & ~t_emu[s] & ~t_ro[s] & ~t_res[s];
      m_fs = s;
      m_fd = 16'h0;
      for (int b = 0; b < 16; b++)
        m_fd[b] = th[b] ? d[b] : (t_w1c[s][b] ? 1'b0 : dev[b]);
      m_emu[s] = (m_emu[s] & ~wm) | (d & wm);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    m_emu = '{16'h0, 16'h0, 16'h0, 16'h0008};
    m_fv = 0; m_fs = 0; m_fd = 0;
    #(CLK_PERIOD * 3);
    // R1: reset values seen through the read port
    for (int r = 0; r < 4; r++) begin
      rd_sel_i = 2'(r);
      #1;
      check("R1 reset emu", emu_val_o, r == 3 ? 16'h0008 : 16'h0000);
    end
    check("R1 reset fwd_valid", {15'd0, fwd_valid_o}, 16'h0);
    rst_ni = 1'b1;
    // R5: write-back of read value with no enabled byte must not clear w1c flags
    for (int r = 0; r < 4; r++) step(1, 2'(r), 2'b00, 16'hFFFF, 16'hFFFF, 2'(r));
    // R3: single-lane writes, each lane separately
    for (int r = 0; r < 4; r++) step(1, 2'(r), 2'b01, 16'hFFFF, 16'hFFFF, 2'(r));
    for (int r = 0; r < 4; r++) step(1, 2'(r), 2'b10, 16'hFFFF, 16'hFFFF, 2'(r));
    // R4 R2: full writes of all ones, then all zeros
    for (int r = 0; r < 4; r++) step(1, 2'(r), 2'b11, 16'hFFFF, 16'h0000, 2'(r));
    for (int r = 0; r < 4; r++) step(1, 2'(r), 2'b11, 16'h0000, 16'hFFFF, 2'(r));
    // R9: idle cycles with busy data inputs
    for (int k = 0; k < 6; k++) step(0, 2'(k), 2'b11, 16'hA5A5, 16'h5A5A, 2'(k));
    // R6: back-to-back writes plus random mix
    for (int k = 0; k < 3000; k++)
      step(1'($urandom_range(0, 3) != 0), 2'($urandom), 2'($urandom),
           16'($urandom), 16'($urandom), 2'($urandom));
    step(0, 0, 0, 0, 0, 3);
    step(0, 0, 0, 0, 0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule